// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets synchronous on-chip logic read and write an external 8192 x 8 asynchronous static RAM. A client raises a request with an address, a direction flag and, for a write, one byte of data, and holds it until the controller returns a one-cycle acknowledge. For a read, the byte sits on the response data port in the acknowledge cycle. Only one transaction is in flight at a time.

On the memory side the controller drives the address bus, a chip select that is low when active, a chip select that is high when active, write enable and output enable (both low when active), and a split data bus. The split bus has an output, an output enable and an input, and the pad ring turns it into the tri-state byte lane. Every nanosecond timing figure is a parameter in picoseconds. The controller turns each one into a whole number of clock cycles, rounding up, with a floor of one cycle.

A write is the overlap of both chip selects with a low write enable, and the controller ends it by raising write enable alone. Output enable stays high for the whole write, so the memory never drives against the controller. After a read, the controller keeps its own drivers off until the memory's output float time has passed. Between transactions the memory is deselected so that it can drop into its low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and in every cycle that follows it with no request, both chip selects are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_ack`=0.
- R2: `mem_we_n` is low only while `mem_cs_n`=0, `mem_cs`=1 and `mem_oe_n`=1.
- R3: For a write, `mem_dq_oe` is 1 and `mem_dq_o` carries the request byte from one cycle before `mem_we_n` falls through one cycle after it rises. Address and data do not change when write enable rises.
- R4: `mem_we_n` is low for exactly WP cycles, with WP = max(ceil(pulse), ceil(data setup), ceil(address-to-end) - 1, ceil(write cycle) - 2). The chip selects and address are already valid one cycle before `mem_we_n` falls.
- R5: For a read, `mem_oe_n` is low with `mem_we_n`=1 and `mem_dq_oe`=0 for exactly RD cycles, with RD = max(ceil(access), ceil(output-enable access), ceil(cycle time)).
- R6: The byte on `mem_dq_i` in the last cycle of the output-enable window appears on `rsp_rdata` in the cycle where `rsp_ack` is 1.
- R7: After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least HZ = ceil(float time) cycles, so the controller never drives while the memory may still be driving.
- R8: `rsp_ack` is 1 for exactly one cycle per transaction, and only after the transaction's last memory cycle.
- R9: From the cycle a transaction selects the memory to its last selected cycle, the chip selects stay active and `mem_addr` does not change. This lasts at least ceil(cycle time) cycles.
- R10: In the acknowledge cycle the memory is deselected. A write is followed by two deselected cycles and a read by HZ+1, before the next selection. A request that is still high during the acknowledge cycle is not taken as a second transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte, valid with `rsp_ack` |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, low active |
| mem_cs | output | 1 | Chip select, high active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_oe_n | output | 1 | Output enable, low active |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
Two events can fall in the same cycle: the acknowledge of one transaction and the arrival of the client's next request. The client changes its inputs in the acknowledge cycle itself. The bench provokes this by issuing requests back to back, mixing read after write, write after read and repeated reads. A behavioural model turns each accepted request into a queue of expected per-cycle pin states. It is compared on every clock, so a duplicate acceptance or a missing deselect gap shows up as a pin mismatch. A model of the memory also flags any cycle where the controller drives while the memory is still driving or floating off.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSET,
      ST_WPUL,
      ST_WHLD,
      ST_RACC,
      ST_RFLT
   } state_e;

   typedef struct packed {
      logic cs_n;
      logic cs;
      logic we_n;
      logic oe_n;
      logic dq_oe;
   } pins_t;

   localparam pins_t PINS_IDLE = '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

   // ceiling of a picosecond figure over the clock period, never below one cycle
   function automatic int ps_to_cyc(input int ps, input int clk_ps);
      int c;
      c = (ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pins_t decode_pins(input state_e s);
      pins_t p;
      p = PINS_IDLE;
      if (s inside {ST_WSET, ST_WPUL, ST_WHLD, ST_RACC}) begin
         p.cs_n = 1'b0;
         p.cs   = 1'b1;
      end
      if (s == ST_WPUL) p.we_n = 1'b0;
      if (s == ST_RACC) p.oe_n = 1'b0;
      if (s inside {ST_WSET, ST_WPUL, ST_WHLD}) p.dq_oe = 1'b1;
      return p;
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int RD_CYC = 2,
   parameter int WP_CYC = 2,
   parameter int HZ_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] rd_byte_i,
   output state_e            st_q,
   output state_e            st_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              ack_q
);
   localparam int CNT_MAX = imax(imax(RD_CYC, WP_CYC), HZ_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ack_d, accept, capture;

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      ack_d   = 1'b0;
      accept  = 1'b0;
      capture = 1'b0;
      case (st_q)
         ST_IDLE: begin
            // the ack cycle still carries the previous request: skip it
            if (req_valid && !ack_q) begin
               accept = 1'b1;
               if (req_write) begin
                  st_d = ST_WSET;
               end else begin
                  st_d  = ST_RACC;
                  cnt_d = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_WSET: begin
            st_d  = ST_WPUL;
            cnt_d = CNT_W'(WP_CYC - 1);
         end
         ST_WPUL: begin
            if (cnt_q == '0) st_d = ST_WHLD;
            else             cnt_d = cnt_q - 1'b1;
         end
         ST_WHLD: begin
            st_d  = ST_IDLE;
            ack_d = 1'b1;
         end
         ST_RACC: begin
            if (cnt_q == '0) begin
               st_d    = ST_RFLT;
               cnt_d   = CNT_W'(HZ_CYC - 1);
               ack_d   = 1'b1;
               capture = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_RFLT: begin
            if (cnt_q == '0) st_d = ST_IDLE;
            else             cnt_d = cnt_q - 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         ack_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         ack_q <= ack_d;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= rd_byte_i;
      end
   end

   // R8: acknowledge never lasts two cycles
   assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  state_e st_q,
   input  state_e st_d,
   output pins_t  pins
);
   generate
      if (OUT_REG) begin : g_reg
         // flops fed from the next state: same timing, glitch-free strobes
         pins_t pins_r;
         logic  unused_st;
         assign unused_st = ^st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pins_r <= PINS_IDLE;
            else        pins_r <= decode_pins(st_d);
         end
         assign pins = pins_r;
      end else begin : g_comb
         logic unused_st;
         assign unused_st = ^st_d;
         assign pins = decode_pins(st_q);
      end
   endgenerate

   // R2: write strobe only inside a full select with outputs disabled
   assert_we_in_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.we_n |-> (!pins.cs_n && pins.cs && pins.oe_n));

   // R5: memory output window never overlaps the controller's drivers
   assert_oe_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.oe_n |-> (!pins.dq_oe && pins.we_n));

   // R7: drivers stay off in the cycle after output enable is released
   assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pins.oe_n) |=> !pins.dq_oe);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter bit OUT_REG   = 1'b1,
   parameter int CLK_PS    = 10000,
   parameter int T_WC_PS   = 15000,
   parameter int T_AA_PS   = 15000,
   parameter int T_DOE_PS  = 8000,
   parameter int T_PWE_PS  = 12000,
   parameter int T_AW_PS   = 12000,
   parameter int T_SD_PS   = 8000,
   parameter int T_HZ_PS   = 7000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int C_WC   = ps_to_cyc(T_WC_PS,  CLK_PS);
   localparam int C_AA   = ps_to_cyc(T_AA_PS,  CLK_PS);
   localparam int C_DOE  = ps_to_cyc(T_DOE_PS, CLK_PS);
   localparam int C_PWE  = ps_to_cyc(T_PWE_PS, CLK_PS);
   localparam int C_AW   = ps_to_cyc(T_AW_PS,  CLK_PS);
   localparam int C_SD   = ps_to_cyc(T_SD_PS,  CLK_PS);
   localparam int C_HZ   = ps_to_cyc(T_HZ_PS,  CLK_PS);
   // one setup cycle and one hold cycle frame the write pulse
   localparam int RD_CYC = imax(imax(C_AA, C_DOE), C_WC);
   localparam int WP_CYC = imax(imax(C_PWE, C_SD), imax(C_AW - 1, C_WC - 2));
   localparam int HZ_CYC = C_HZ;

   initial begin
      assert_param_widths: assert (ADDR_W >= 1 && DATA_W >= 1)
         else $error("address and data widths must be positive");
      assert_param_clock: assert (CLK_PS > 0)
         else $error("clock period must be positive");
   end

   state_e            st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   pins_t             pins;

   sram_ctrl_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .RD_CYC (RD_CYC),
      .WP_CYC (WP_CYC),
      .HZ_CYC (HZ_CYC)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rd_byte_i (mem_dq_i),
      .st_q      (st_q),
      .st_d      (st_d),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .rdata_q   (rsp_rdata),
      .ack_q     (rsp_ack)
   );

   sram_ctrl_pins #(
      .OUT_REG (OUT_REG)
   ) pins_i (
      .clk   (clk),
      .rst_n (rst_n),
      .st_q  (st_q),
      .st_d  (st_d),
      .pins  (pins)
   );

   assign mem_addr  = addr_q;
   assign mem_dq_o  = wdata_q;
   assign mem_cs_n  = pins.cs_n;
   assign mem_cs    = pins.cs;
   assign mem_we_n  = pins.we_n;
   assign mem_oe_n  = pins.oe_n;
   assign mem_dq_oe = pins.dq_oe;

   // R3: data driven and address/data steady on the write-ending edge
   assert_write_end_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

   // R4: drivers already on a cycle before the write strobe falls
   assert_write_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_dq_oe));

   // R9: address frozen while the memory stays selected
   assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   // R10: memory deselected whenever completion is signalled
   assert_ack_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> (mem_cs_n && !mem_cs));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
   localparam int CLK_NS = 10;
   localparam int AW = 13;
   localparam int DW = 8;
   // cycle counts worked out from the requirements for a 10 ns clock
   localparam int N_RD = 2;  // max(ceil 15/10, ceil 8/10, ceil 15/10)
   localparam int N_WP = 2;  // max(ceil 12/10, ceil 8/10, 2-1, 2-2)
   localparam int N_HZ = 1;  // ceil 7/10

   typedef struct packed {
      logic act;
      logic we_n;
      logic oe_n;
      logic drv;
      logic ack;
      logic rd;
   } exp_t;
   localparam exp_t E_IDLE = '{act: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, ack: 1'b0, rd: 1'b0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic rsp_ack;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_o;
   logic [DW-1:0] mem_dq_i = '0;

   int n_chk = 0, n_err = 0, cyc = 0;

   always #(CLK_NS/2) clk = ~clk;

   sram_async_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   // memory contents; unwritten bytes read back a pattern of the address
   logic [DW-1:0] mem [int];
   function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : (a[7:0] ^ 8'h3C);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // reference model: per-cycle expectations queued on acceptance
   exp_t q[$];
   exp_t cur = E_IDLE;
   logic [AW-1:0] t_addr = '0;
   logic [DW-1:0] t_wdata = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         cur = E_IDLE;
      end else begin
         if (q.size() == 0 && req_valid) begin
            t_addr = req_addr;
            t_wdata = req_wdata;
            if (req_write) begin
               q.push_back('{act:1, we_n:1, oe_n:1, drv:1, ack:0, rd:0});
               for (int i = 0; i < N_WP; i++) q.push_back('{act:1, we_n:0, oe_n:1, drv:1, ack:0, rd:0});
               q.push_back('{act:1, we_n:1, oe_n:1, drv:1, ack:0, rd:0});
               q.push_back('{act:0, we_n:1, oe_n:1, drv:0, ack:1, rd:0});
               q.push_back(E_IDLE);
            end else begin
               for (int i = 0; i < N_RD; i++) q.push_back('{act:1, we_n:1, oe_n:0, drv:0, ack:0, rd:0});
               q.push_back('{act:0, we_n:1, oe_n:1, drv:0, ack:1, rd:1});
               for (int i = 1; i < N_HZ; i++) q.push_back(E_IDLE);
               q.push_back(E_IDLE);
            end
         end
         cur = (q.size() != 0) ? q.pop_front() : E_IDLE;
      end
   end

   // compare, memory model and contention monitor, all away from the rising edge
   logic prev_drv = 1'b0;
   int   float_left = 0;
   always @(negedge clk) begin
      logic sel, mdrv;
      cyc++;
      if (cyc > 100000) begin
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
      sel  = !mem_cs_n && mem_cs;
      mdrv = sel && !mem_oe_n && mem_we_n;
      if (rst_n) begin
         chk(mem_cs_n == !cur.act && mem_cs == cur.act, cur.act ? "R9" : "R10", "select",
             int'({mem_cs_n, mem_cs}), int'({!cur.act, cur.act}));
         chk(mem_we_n == cur.we_n, "R4", "we_n", int'(mem_we_n), int'(cur.we_n));
         chk(mem_oe_n == cur.oe_n, "R5", "oe_n", int'(mem_oe_n), int'(cur.oe_n));
         chk(mem_dq_oe == cur.drv, "R3", "dq_oe", int'(mem_dq_oe), int'(cur.drv));
         chk(rsp_ack == cur.ack, "R8", "ack", int'(rsp_ack), int'(cur.ack));
         if (!mem_we_n)
            chk(sel && mem_oe_n, "R2", "strobe outside select", int'({sel, mem_oe_n}), 3);
         if (cur.act) chk(mem_addr == t_addr, "R9", "address", int'(mem_addr), int'(t_addr));
         if (cur.drv) chk(mem_dq_o == t_wdata, "R3", "write data", int'(mem_dq_o), int'(t_wdata));
         if (cur.ack && cur.rd)
            chk(rsp_rdata == mem_rd(t_addr), "R6", "read data", int'(rsp_rdata), int'(mem_rd(t_addr)));
         if (prev_drv && !mdrv) float_left = N_HZ;
         chk(!(mem_dq_oe && (mdrv || float_left > 0)), "R7", "bus contention",
             int'(mem_dq_oe), 0);
         if (float_left > 0) float_left--;
      end
      prev_drv = mdrv;
      if (sel && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_o;
      mem_dq_i = mdrv ? mem_rd(mem_addr) : 8'h00;
   end

   task automatic txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      forever begin
         @(negedge clk);
         if (rsp_ack) break;
      end
   endtask

   task automatic gap(input int n);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R1: pins inactive while reset is held
      repeat (3) begin
         @(negedge clk);
         chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_ack, "R1",
             "reset pins", int'({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, rsp_ack}), 6'b101100);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(mem_cs_n && !mem_cs && !mem_dq_oe && !rsp_ack, "R1", "idle after reset",
          int'({mem_cs_n, mem_cs, mem_dq_oe, rsp_ack}), 4'b1000);
      // boundary addresses and data patterns
      txn(1'b1, 13'h0000, 8'hA5);
      txn(1'b1, 13'h1FFF, 8'hFF);
      txn(1'b0, 13'h0000, 8'h00);
      txn(1'b0, 13'h1FFF, 8'h00);
      gap(4);
      txn(1'b1, 13'h1234, 8'h00);
      txn(1'b0, 13'h1234, 8'h11);
      txn(1'b0, 13'h0ABC, 8'h00);   // never written
      // back-to-back mix: write after read, read after write, repeated reads
      for (int i = 0; i < 24; i++) begin
         logic [AW-1:0] a;
         a = AW'((i * 397) % 8192);
         txn(1'b1, a, DW'(i * 37 + 5));
         txn(1'b0, a, 8'h00);
         if (i % 5 == 0) txn(1'b0, AW'(a + 1), 8'h00);
         if (i % 7 == 3) gap(i % 3 + 1);
      end
      txn(1'b0, 13'h0000, 8'h00);
      gap(5);
      chk(mem_cs_n && !mem_cs && !rsp_ack, "R10", "deselected at end",
          int'({mem_cs_n, mem_cs, rsp_ack}), 3'b100);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule